// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a circular register file that presents 32 logical registers to a datapath through a current window pointer. Logical registers 0 to 9 are globals that every window shares, and register 0 always reads as zero. Logical registers 10 to 31 are resolved through the pointer. Each window has three groups. The incoming group is registers 26 to 31. The private locals are registers 16 to 25. The outgoing group is registers 10 to 15.

Windows overlap. When a routine issues a call, the values it placed in its outgoing group appear in the callee's incoming group without any copying. A call moves the pointer forward one window and a return moves it back one. The pointer wraps around the ring. A count of resident windows raises a one-cycle overflow or underflow flag when the ring is exhausted in either direction. The pointer still moves, so that a trap handler can spill or refill windows. Spilling itself is not part of this block.

The file has two combinational read ports and one write port, all addressed by logical register number. A write in the same cycle as a pointer move goes through the mapping that was in force before the move. Reads in the following cycle see the new mapping.

Top module: `rwf_file`

## Requirements
- R1: Logical registers 1 to 9 map to the same storage in every window: a value written to one of them in any window reads back unchanged in every other window.
- R2: Logical register 0 reads as zero on both read ports, and a write to it has no effect.
- R3: A call pulse alone advances the window pointer by one, wrapping from NWIN-1 to 0. A return pulse alone moves it back by one, wrapping from 0 to NWIN-1. When call and return arrive in the same cycle, the pointer, the resident count and both flags stay unchanged.
- R4: After a call, logical register 26+k in the callee window reads the value the caller wrote to logical register 10+k, for k = 0 to 5.
- R5: Logical registers 16 to 25 are private to each window: writes made in any other window never alter them.
- R6: The ring is circular. The outgoing group of window NWIN-1 is the incoming group of window 0.
- R7: The resident window count starts at 1. A call made while NWIN-1 windows are resident drives overflow_o high for exactly the next cycle and leaves the count unchanged. Any other call adds one to the count.
- R8: A return made while exactly one window is resident drives underflow_o high for exactly the next cycle and leaves the count unchanged. Any other return takes one from the count. Overflow and underflow are never high together.
- R9: A write presented in the same cycle as a call or return lands in the register that the logical address names under the pointer value held before the move.
- R10: Reads are combinational under the current pointer. After reset the pointer is 0, both flags are low and the resident count is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| call_i | input | 1 | Call pulse: advance the window pointer |
| ret_i | input | 1 | Return pulse: move the window pointer back |
| ra1_i | input | 5 | Read port 1 logical register number |
| rd1_o | output | DATA_W | Read port 1 data |
| ra2_i | input | 5 | Read port 2 logical register number |
| rd2_o | output | DATA_W | Read port 2 data |
| we_i | input | 1 | Write enable |
| wa_i | input | 5 | Write logical register number |
| wd_i | input | DATA_W | Write data |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| overflow_o | output | 1 | One-cycle pulse: a call found the ring full |
| underflow_o | output | 1 | One-cycle pulse: a return found no saved window |

## Verification
Two events can meet in one clock edge: a pointer move and a register write. The bench provokes this on every window of a full lap around the ring. The last outgoing-parameter write of each window is issued in the same cycle as the call. After the move, the bench reads the callee's matching incoming register and expects the value just written. A second meeting is a call and a return in the same cycle. The bench judges that one by checking that the pointer, the flags and the later overflow and underflow points are all unchanged.

// File: rtl/rwf_pkg.sv
`timescale 1ns/1ps
package rwf_pkg;
  localparam int LREG_W      = 5;
  localparam int NUM_GLOBAL  = 10;
  localparam int WIN_STRIDE  = 16;
  localparam int TOP_LREG    = 31;
  typedef logic [LREG_W-1:0] lreg_t;
endpackage

// File: rtl/rwf_rst_sync.sv
`timescale 1ns/1ps
module rwf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/rwf_window_ctrl.sv
`timescale 1ns/1ps
module rwf_window_ctrl #(
  parameter int NWIN = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      call_i,
  input  logic                      ret_i,
  output logic [$clog2(NWIN)-1:0]   cwp_o,
  output logic                      overflow_o,
  output logic                      underflow_o
);
  localparam int CWP_W  = $clog2(NWIN);
  localparam int CNT_W  = $clog2(NWIN + 1);
  localparam logic [CWP_W-1:0] LAST_WIN = CWP_W'(NWIN - 1);
  localparam logic [CNT_W-1:0] MAX_RES  = CNT_W'(NWIN - 1);
  localparam logic [CNT_W-1:0] ONE_RES  = CNT_W'(1);

  logic [CWP_W-1:0] cwp_q, cwp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             unf_q, unf_d;
  logic             go_fwd, go_back, step_en;

  assign go_fwd  = call_i & ~ret_i;
  assign go_back = ret_i & ~call_i;
  assign step_en = go_fwd | go_back;

  always_comb begin
    cwp_d = cwp_q;
    cnt_d = cnt_q;
    ovf_d = 1'b0;
    unf_d = 1'b0;
    if (go_fwd) begin
      cwp_d = (cwp_q == LAST_WIN) ? '0 : cwp_q + 1'b1;
      if (cnt_q == MAX_RES) ovf_d = 1'b1;
      else                  cnt_d = cnt_q + 1'b1;
    end else if (go_back) begin
      cwp_d = (cwp_q == '0) ? LAST_WIN : cwp_q - 1'b1;
      if (cnt_q == ONE_RES) unf_d = 1'b1;
      else                  cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q <= '0;
      cnt_q <= ONE_RES;
    end else if (step_en) begin
      cwp_q <= cwp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign cwp_o       = cwp_q;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;

  // R3
  cwp_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i) |=> (cwp_q == (($past(cwp_q) == LAST_WIN) ? '0 : $past(cwp_q) + 1'b1)));
  // R3
  cwp_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i) |=> (cwp_q == (($past(cwp_q) == '0) ? LAST_WIN : $past(cwp_q) - 1'b1)));
  // R3
  cwp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i == ret_i) |=> ($stable(cwp_q) && $stable(cnt_q) && !ovf_q && !unf_q));
  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(go_fwd));
  // R8
  unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unf_q) |-> $past(go_back));
  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ovf_q, unf_q}) <= 1);
  // R7
  res_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= ONE_RES) && (cnt_q <= MAX_RES));
endmodule

// File: rtl/rwf_addr_map.sv
`timescale 1ns/1ps
module rwf_addr_map
  import rwf_pkg::*;
#(
  parameter int NWIN = 8
) (
  input  logic [$clog2(NWIN)-1:0]               cwp_i,
  input  lreg_t                                 lreg_i,
  output logic [$clog2(NUM_GLOBAL+NWIN*WIN_STRIDE)-1:0] phys_o,
  output logic                                  is_zero_o
);
  localparam int CWP_W   = $clog2(NWIN);
  localparam int RING    = NWIN * WIN_STRIDE;
  localparam int PHYS    = NUM_GLOBAL + RING;
  localparam int PA_W    = $clog2(PHYS);
  localparam int RING_AW = $clog2(2 * RING);

  logic [RING_AW-1:0] base_w, flip_w, sum_w, wrap_w;

  always_comb begin
    base_w = RING_AW'(cwp_i) * RING_AW'(WIN_STRIDE);
    flip_w = RING_AW'(lreg_t'(TOP_LREG) - lreg_i);
    sum_w  = base_w + flip_w;
    wrap_w = (sum_w >= RING_AW'(RING)) ? sum_w - RING_AW'(RING) : sum_w;
    if (lreg_i < lreg_t'(NUM_GLOBAL)) phys_o = PA_W'(lreg_i);
    else                              phys_o = PA_W'(wrap_w) + PA_W'(NUM_GLOBAL);
  end

  assign is_zero_o = (lreg_i == '0);
endmodule

// File: rtl/rwf_storage.sv
`timescale 1ns/1ps
module rwf_storage #(
  parameter int DATA_W = 32,
  parameter int PHYS   = 138,
  parameter int NRD    = 2
) (
  input  logic                                 clk,
  input  logic                                 we_i,
  input  logic [$clog2(PHYS)-1:0]              wa_i,
  input  logic [DATA_W-1:0]                    wd_i,
  input  logic [NRD-1:0][$clog2(PHYS)-1:0]     ra_i,
  input  logic [NRD-1:0]                       rzero_i,
  output logic [NRD-1:0][DATA_W-1:0]           rd_o
);
  localparam int PA_W = $clog2(PHYS);

  logic [DATA_W-1:0] mem [PHYS];
  logic [PHYS-1:0]   row_en;

  always_comb begin
    for (int i = 0; i < PHYS; i++) begin
      row_en[i] = we_i && (wa_i == PA_W'(i)) && (i != 0);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PHYS; i++) begin
      if (row_en[i]) mem[i] <= wd_i;
    end
  end

  generate
    for (genvar p = 0; p < NRD; p++) begin : g_rport
      assign rd_o[p] = rzero_i[p] ? '0 : mem[ra_i[p]];
    end
  endgenerate
endmodule

// File: rtl/rwf_file.sv
`timescale 1ns/1ps
module rwf_file
  import rwf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NWIN   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    call_i,
  input  logic                    ret_i,
  input  logic [4:0]              ra1_i,
  output logic [DATA_W-1:0]       rd1_o,
  input  logic [4:0]              ra2_i,
  output logic [DATA_W-1:0]       rd2_o,
  input  logic                    we_i,
  input  logic [4:0]              wa_i,
  input  logic [DATA_W-1:0]       wd_i,
  output logic [$clog2(NWIN)-1:0] cwp_o,
  output logic                    overflow_o,
  output logic                    underflow_o
);
  localparam int CWP_W = $clog2(NWIN);
  localparam int PHYS  = NUM_GLOBAL + NWIN * WIN_STRIDE;
  localparam int PA_W  = $clog2(PHYS);
  localparam int NRD   = 2;
  localparam int NMAP  = NRD + 1;

  logic                          rst_n_int;
  logic [CWP_W-1:0]              cwp;
  lreg_t                         lreg   [NMAP];
  logic [NMAP-1:0][PA_W-1:0]     phys;
  logic [NMAP-1:0]               zero;
  logic [NRD-1:0][PA_W-1:0]      rd_phys;
  logic [NRD-1:0][DATA_W-1:0]    rd_data;

  rwf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  rwf_window_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .cwp_o       (cwp),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o)
  );

  assign lreg[0] = ra1_i;
  assign lreg[1] = ra2_i;
  assign lreg[2] = wa_i;

  generate
    for (genvar m = 0; m < NMAP; m++) begin : g_map
      rwf_addr_map #(.NWIN(NWIN)) u_map (
        .cwp_i     (cwp),
        .lreg_i    (lreg[m]),
        .phys_o    (phys[m]),
        .is_zero_o (zero[m])
      );
    end
  endgenerate

  assign rd_phys[0] = phys[0];
  assign rd_phys[1] = phys[1];

  rwf_storage #(.DATA_W(DATA_W), .PHYS(PHYS), .NRD(NRD)) u_store (
    .clk     (clk),
    .we_i    (we_i & ~zero[2]),
    .wa_i    (phys[2]),
    .wd_i    (wd_i),
    .ra_i    (rd_phys),
    .rzero_i (zero[NRD-1:0]),
    .rd_o    (rd_data)
  );

  assign rd1_o = rd_data[0];
  assign rd2_o = rd_data[1];
  assign cwp_o = cwp;

  // R2
  zero_rd1_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ra1_i == 5'd0) |-> (rd1_o == '0));
  // R2
  zero_rd2_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ra2_i == 5'd0) |-> (rd2_o == '0));
  // R1
  global_map_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ra1_i < 5'd10) |-> (phys[0] == PA_W'(ra1_i)));
endmodule

// File: tb/tb_rwf_file.sv
`timescale 1ns/1ps
module tb_rwf_file;
  localparam int DATA_W = 32;
  localparam int NWIN   = 8;

  logic              clk;
  logic              rst_n;
  logic              call_i, ret_i, we_i;
  logic [4:0]        ra1_i, ra2_i, wa_i;
  logic [DATA_W-1:0] wd_i, rd1_o, rd2_o;
  logic [2:0]        cwp_o;
  logic              overflow_o, underflow_o;

  int tests;
  int fails;
  int m_cwp;
  int m_cnt;

  rwf_file #(.DATA_W(DATA_W), .NWIN(NWIN)) dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .ra1_i(ra1_i), .rd1_o(rd1_o), .ra2_i(ra2_i), .rd2_o(rd2_o),
    .we_i(we_i), .wa_i(wa_i), .wd_i(wd_i),
    .cwp_o(cwp_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] gval(int n);
    return 32'h6000_0000 + 32'(n) * 32'h111;
  endfunction
  function automatic logic [31:0] lval(int w, int n);
    return 32'hA000_0000 | (32'(w) << 12) | 32'(n);
  endfunction
  function automatic logic [31:0] pval(int w, int n);
    return 32'h5000_0000 | (32'(w) << 16) | (32'(n) << 4) | 32'h7;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic c, logic r, logic w, logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    call_i = c; ret_i = r; we_i = w; wa_i = a; wd_i = d;
    @(posedge clk);
    #1;
    call_i = 1'b0; ret_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    ra1_i = a; ra2_i = a;
    #1;
    chk(req, rd1_o, exp);
  endtask

  task automatic flags(logic eo, logic eu, string req);
    @(negedge clk);
    chk({req, " overflow"}, 32'(overflow_o), 32'(eo));
    chk({req, " underflow"}, 32'(underflow_o), 32'(eu));
    chk({req, " cwp"}, 32'(cwp_o), 32'(m_cwp));
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0;
    call_i = 0; ret_i = 0; we_i = 0; wa_i = 0; wd_i = 0; ra1_i = 0; ra2_i = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_cwp = 0; m_cnt = 1;

    // R10 reset state
    flags(1'b0, 1'b0, "R10 reset");
    rd(5'd0, 32'h0, "R10 r0 after reset");

    // R1 globals and R2 r0 write ignored
    for (int n = 1; n < 10; n++) step(0, 0, 1, 5'(n), gval(n));
    step(0, 0, 1, 5'd0, 32'hDEAD_BEEF);
    rd(5'd0, 32'h0, "R2 r0 port1");
    #1 chk("R2 r0 port2", rd2_o, 32'h0);

    // lap around the ring, write during call (R9), aliasing (R4/R6), overflow (R7)
    for (int w = 0; w < NWIN; w++) begin
      for (int n = 16; n < 26; n++) step(0, 0, 1, 5'(n), lval(w, n));
      for (int n = 10; n < 15; n++) step(0, 0, 1, 5'(n), pval(w, n));
      step(1, 0, 1, 5'd15, pval(w, 15));
      m_cwp = (m_cwp + 1) % NWIN;
      if (m_cnt == NWIN - 1) flags(1'b1, 1'b0, "R7 call at full ring");
      else begin m_cnt++; flags(1'b0, 1'b0, "R7 call with room"); end
      rd(5'd31, pval(w, 15), "R9 write in call cycle, old mapping");
      for (int k = 0; k < 5; k++)
        rd(5'(26 + k), pval(w, 10 + k), (w == NWIN - 1) ? "R6 ring wrap alias" : "R4 param alias");
      for (int n = 1; n < 10; n += 4) rd(5'(n), gval(n), "R1 global in new window");
    end
    for (int n = 16; n < 26; n++) rd(5'(n), lval(0, n), "R5 locals of window 0 after lap");

    // returns and underflow (R8), locals private (R5)
    for (int i = 0; i < NWIN; i++) begin
      step(0, 1, 0, 5'd0, 32'h0);
      m_cwp = (m_cwp + NWIN - 1) % NWIN;
      if (m_cnt == 1) flags(1'b0, 1'b1, "R8 return with one resident");
      else begin m_cnt--; flags(1'b0, 1'b0, "R8 return with saved windows"); end
      for (int n = 16; n < 26; n += 3) rd(5'(n), lval(m_cwp, n), "R5 locals after return");
    end

    // R3 simultaneous call and return: no change
    step(1, 1, 0, 5'd0, 32'h0);
    flags(1'b0, 1'b0, "R3 call+return same cycle");
    // count unchanged at 1: a return now must underflow
    step(0, 1, 0, 5'd0, 32'h0);
    m_cwp = (m_cwp + NWIN - 1) % NWIN;
    flags(1'b0, 1'b1, "R3 count held by call+return");
    // R3 forward and back wrap
    step(1, 0, 0, 5'd0, 32'h0);
    m_cwp = (m_cwp + 1) % NWIN; m_cnt = 2;
    flags(1'b0, 1'b0, "R3 call wraps pointer");
    rd(5'd9, gval(9), "R1 global after wraps");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule